// File: doc/BRIEF.md
# Routable interrupt aggregation controller

This block gathers 32 level-sensitive interrupt request lines and steers each one to one of 15 level outputs, each wired to a processor interrupt pin. Software reaches it through a plain 32-bit register port. Through that port it sets a per-input enable mask, reads the live input levels, and gives every input a 4-bit route code. A code of 0 leaves the input unconnected. A code v from 1 to 15 sends the input to output v-1.

An input counts as pending only while it is both high and enabled. Each output is the registered OR of all pending inputs whose route code selects it. A multi-core system builds one instance per core, and each instance has its own mask and route setup.

Top module: `irq_route_ctrl`

## Requirements
- R1: After the asynchronous reset, the enable mask, every route field and every output are zero.
- R2: The enable mask lives at byte offset 0x00. It is read/write, and bit n enables input n.
- R3: Offset 0x04 reads the raw level of the 32 inputs, with bit n being input n. Writes to this offset change no register.
- R4: Route registers sit at offsets 0x08, 0x0C, 0x10 and 0x14. Offset 0x08+4*r holds inputs 8*(3-r) to 8*(3-r)+7, so inputs 24..31 are at 0x08 and inputs 0..7 are at 0x14. Input n uses bits [4*(n mod 8)+3 : 4*(n mod 8)] of its register.
- R5: An input whose route code is 0 drives no output.
- R6: An input whose route code is v (1..15) drives only output v-1.
- R7: An input is pending only when its mask bit and its level are both 1. A masked input never raises an output.
- R8: Output k is the OR of every pending input routed to it, so several inputs may share one output.
- R9: Outputs are registered. A change of an input, the mask or a route shows at the outputs exactly one clock edge later.
- R10: Reads of any other offset return zero. Writes to any other offset change no register.
- R11: Writing a route register replaces all eight of its fields with the written data. Writing back a read value with one field changed leaves the other seven fields as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 32 | Level interrupt inputs |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, zero when no read is requested |
| irq_o | output | 15 | Level interrupt outputs |

## Verification
A mask write and a change of input levels can land on the same clock edge. Both feed the same pending term, and the output must reflect their combined result exactly one edge later. The bench provokes this by changing the inputs in the same cycle that it writes a new pseudo-random mask, with a route map that sends pairs of inputs to shared outputs and leaves some inputs unconnected. It then judges the outputs one clock later against an arithmetic model of mask, level and route code. A separate sweep moves every input through all 15 codes by read-modify-write and checks the neighbouring fields after each step.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;
  localparam int unsigned RT_W       = 4;
  localparam int unsigned OFS_MASK   = 'h00;
  localparam int unsigned OFS_STAT   = 'h04;
  localparam int unsigned OFS_ROUTE0 = 'h08;
endpackage

// File: rtl/irq_rt_regs.sv
module irq_rt_regs
  import irq_rt_pkg::*;
#(
  parameter int unsigned N_IN = 32,
  parameter int unsigned DW   = 32,
  parameter int unsigned AW   = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_IN-1:0]      irq_i,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  output logic [N_IN-1:0]      mask_o,
  output logic [N_IN*RT_W-1:0] route_o
);
  localparam int unsigned FPR = DW / RT_W;
  localparam int unsigned NREG = N_IN / FPR;
  localparam int unsigned RIW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [AW-1:0] A_MASK = AW'(OFS_MASK);
  localparam logic [AW-1:0] A_STAT = AW'(OFS_STAT);
  localparam logic [AW-1:0] A_RT0  = AW'(OFS_ROUTE0);

  logic [N_IN-1:0]      mask_q;
  logic [N_IN*RT_W-1:0] route_q;
  logic [AW-1:0]        rel;
  logic [RIW-1:0]       ridx;
  logic                 is_mask, is_stat, is_route, unmapped;

  assign is_mask  = (addr_i == A_MASK);
  assign is_stat  = (addr_i == A_STAT);
  assign rel      = addr_i - A_RT0;
  assign ridx     = rel[2 +: RIW];
  assign is_route = (addr_i >= A_RT0) && (rel[1:0] == 2'b00) &&
                    ({2'b00, rel[AW-1:2]} < AW'(NREG));
  assign unmapped = !(is_mask || is_stat || is_route);

  // reverse packing: register r holds the highest group first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      route_q <= '0;
    end else if (req_i && we_i) begin
      if (is_mask) mask_q <= wdata_i[N_IN-1:0];
      if (is_route) begin
        for (int f = 0; f < int'(FPR); f++)
          route_q[((int'(NREG) - 1 - int'(ridx)) * int'(FPR) + f) * int'(RT_W) +: RT_W]
            <= wdata_i[f*RT_W +: RT_W];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      if (is_mask) rdata_o = DW'(mask_q);
      else if (is_stat) rdata_o = DW'(irq_i);
      else if (is_route) begin
        for (int f = 0; f < int'(FPR); f++)
          rdata_o[f*RT_W +: RT_W] =
            route_q[((int'(NREG) - 1 - int'(ridx)) * int'(FPR) + f) * int'(RT_W) +: RT_W];
      end
    end
  end

  assign mask_o  = mask_q;
  assign route_o = route_q;

  assert_mask_wr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && is_mask) |=> (mask_o == $past(wdata_i[N_IN-1:0])));
  assert_stat_ro_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && is_stat) |=> ($stable(mask_o) && $stable(route_o)));
  assert_unmapped_wr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && unmapped) |=> ($stable(mask_o) && $stable(route_o)));
  assert_unmapped_rd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && unmapped) |-> (rdata_o == '0));
endmodule

// File: rtl/irq_rt_fanin.sv
module irq_rt_fanin
  import irq_rt_pkg::*;
#(
  parameter int unsigned N_IN  = 32,
  parameter int unsigned N_OUT = 15
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_IN-1:0]      pend_i,
  input  logic [N_IN*RT_W-1:0] route_i,
  output logic [N_OUT-1:0]     out_o
);
  logic [N_OUT-1:0] hit;

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    always_comb begin
      hit[k] = 1'b0;
      for (int n = 0; n < int'(N_IN); n++)
        if (pend_i[n] && (route_i[n*RT_W +: RT_W] == RT_W'(k + 1))) hit[k] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_o <= '0;
    else         out_o <= hit;
  end
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_rt_pkg::*;
#(
  parameter int unsigned N_IN  = 32,
  parameter int unsigned N_OUT = 15,
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IN-1:0]  irq_i,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic [N_OUT-1:0] irq_o
);
  logic [N_IN-1:0]      mask;
  logic [N_IN*RT_W-1:0] route;
  logic [N_IN-1:0]      pend;

  irq_rt_regs #(.N_IN(N_IN), .DW(DW), .AW(AW)) u_regs (
    .clk_i, .rst_ni, .irq_i, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .mask_o(mask), .route_o(route)
  );

  assign pend = mask & irq_i;

  irq_rt_fanin #(.N_IN(N_IN), .N_OUT(N_OUT)) u_fanin (
    .clk_i, .rst_ni, .pend_i(pend), .route_i(route), .out_o(irq_o)
  );

  assert_masked_silent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pend) == '0) |-> (irq_o == '0));
  assert_one_dest_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(irq_o) <= $countones($past(pend)));
endmodule

// File: tb/irq_route_ctrl_bench.sv
`timescale 1ns/1ps
module irq_route_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [14:0] out;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_mask = '0;
  logic [3:0]  exp_route [32];
  logic [31:0] lfsr = 32'hACE1_2468;

  always #2.5 clk = ~clk;

  irq_route_ctrl u_irq_route_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  function automatic logic [7:0] reg_of(input int n);
    return 8'h08 + 8'(4 * (3 - n / 8));
  endfunction

  function automatic logic [31:0] exp_reg(input int r);
    logic [31:0] v = '0;
    for (int f = 0; f < 8; f++) v[f*4 +: 4] = exp_route[(3 - r) * 8 + f];
    return v;
  endfunction

  function automatic logic [14:0] model_out(input logic [31:0] m, input logic [31:0] l);
    logic [14:0] o = '0;
    for (int n = 0; n < 32; n++)
      if (m[n] && l[n] && exp_route[n] != 4'd0) o[exp_route[n] - 4'd1] = 1'b1;
    return o;
  endfunction

  function automatic logic [31:0] step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int n = 0; n < 32; n++) exp_route[n] = 4'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, v); check("R1 mask", v, 32'h0);
    for (int r = 0; r < 4; r++) begin
      rd(8'h08 + 8'(4 * r), v); check("R1 route", v, 32'h0);
    end
    check("R1 out", 32'(out), 32'h0);

    // R2 mask read/write
    foreach (v[i]) ;
    wr(8'h00, 32'hA5A5_0F0F); rd(8'h00, v); check("R2 mask", v, 32'hA5A5_0F0F);
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v); check("R2 mask", v, 32'hFFFF_FFFF);
    exp_mask = 32'hFFFF_FFFF;

    // R3 status read-only
    irq = 32'h1234_8001;
    rd(8'h04, v); check("R3 status", v, 32'h1234_8001);
    wr(8'h04, 32'h0);
    rd(8'h04, v); check("R3 status after write", v, 32'h1234_8001);
    rd(8'h00, v); check("R3 mask kept", v, exp_mask);
    for (int r = 0; r < 4; r++) begin
      rd(8'h08 + 8'(4 * r), v); check("R3 route kept", v, 32'h0);
    end
    check("R5 unrouted quiet", 32'(out), 32'h0);

    // R4 R5 R6 R11 sweep every input over every code by read-modify-write
    for (int n = 0; n < 32; n++) begin
      irq = 32'h1 << n;
      for (int c = 1; c <= 16; c++) begin
        logic [3:0] code = (c == 16) ? 4'd0 : 4'(c);
        rd(reg_of(n), v);
        v[(n % 8) * 4 +: 4] = code;
        wr(reg_of(n), v);
        exp_route[n] = code;
        rd(reg_of(n), v);
        check("R4 R11 route readback", v, exp_reg(3 - n / 8));
        if (code == 4'd0) check("R5 disconnected", 32'(out), 32'h0);
        else check("R6 routed output", 32'(out), 32'(15'h1 << (code - 4'd1)));
      end
    end

    // R9 latency
    exp_route[5] = 4'd3;
    wr(reg_of(5), exp_reg(3 - 5 / 8));
    irq = 32'h0;
    @(negedge clk); @(negedge clk);
    irq = 32'h20;
    #1 check("R9 not yet", 32'(out), 32'h0);
    @(negedge clk); #1 check("R9 one edge", 32'(out), 32'h4);
    irq = 32'h0;
    #1 check("R9 hold", 32'(out), 32'h4);
    @(negedge clk); #1 check("R9 drop", 32'(out), 32'h0);

    // R7 R8 shared outputs, mask and level changing together
    for (int n = 0; n < 32; n++) exp_route[n] = 4'(n % 16);
    for (int r = 0; r < 4; r++) wr(8'h08 + 8'(4 * r), exp_reg(r));
    for (int i = 0; i < 120; i++) begin
      lfsr = step(lfsr); exp_mask = lfsr;
      lfsr = step(lfsr);
      @(negedge clk);
      irq = lfsr; req = 1'b1; we = 1'b1; addr = 8'h00; wdata = exp_mask;
      @(negedge clk); req = 1'b0; we = 1'b0;
      @(negedge clk);
      check("R7 R8 random out", 32'(out), 32'(model_out(exp_mask, irq)));
      if (i % 8 == 0) begin
        rd(8'h04, v); check("R3 status random", v, irq);
      end
    end
    wr(8'h00, 32'h0); exp_mask = '0;
    irq = 32'hFFFF_FFFF;
    @(negedge clk); @(negedge clk);
    check("R7 all masked", 32'(out), 32'h0);

    // R10 unmapped
    wr(8'h00, 32'h0F0F_0F0F); exp_mask = 32'h0F0F_0F0F;
    wr(8'h18, 32'hFFFF_FFFF); wr(8'h02, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF); wr(8'h09, 32'hFFFF_FFFF);
    rd(8'h00, v); check("R10 mask kept", v, exp_mask);
    for (int r = 0; r < 4; r++) begin
      rd(8'h08 + 8'(4 * r), v); check("R10 route kept", v, exp_reg(r));
    end
    rd(8'h18, v); check("R10 read 0x18", v, 32'h0);
    rd(8'h02, v); check("R10 read 0x02", v, 32'h0);
    rd(8'hFC, v); check("R10 read 0xFC", v, 32'h0);
    rd(8'h0A, v); check("R10 read 0x0A", v, 32'h0);
    check("R8 final out", 32'(out), 32'(model_out(exp_mask, irq)));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule